// File: doc/BRIEF.md
# Dual Byte-Buffer Unit for a Serial Flash Slave

This block is the device-side buffer logic of a serial flash. It owns two independent data buffers of 528 bytes each. A host on an SPI-style slave link (chip select, serial clock, data in, data out) can fill either buffer or stream it back out. Every command has three parts, in this order: a one-byte command code, a three-byte address, and then a data stream. The stream keeps going until chip select is released. The byte pointer starts at the low ten address bits, folded into range. It runs past the last byte back to byte 0.

The program engine reads buffer contents through one private read port per buffer. It holds a separate busy lock on each buffer while that buffer feeds an array program. A host command aimed at a locked buffer is dropped, and the other buffer stays fully usable. The serial lines are sampled by the block's own system clock through a two-stage synchronizer, so the serial clock must run well below the system clock (at least four system clocks per serial half period).

Top module: `dfbuf_unit`

## Requirements
- R1: The block holds two buffers, A and B, of 528 bytes each. Each engine read port returns, in the same cycle, the byte stored at its address. Addresses 528 and above read as 0.
- R2: Code 0x84 writes buffer A and code 0x87 writes buffer B. Code, address and data are shifted most significant bit first, 8 serial clocks per byte, with data-in sampled on the serial clock's rising edge. Each complete data byte is stored at the pointer, and the pointer then advances.
- R3: Code 0xD4 reads buffer A and code 0xD6 reads buffer B. The first data bit is driven on the falling serial clock edge right after the 24th address bit, and later bits follow on each falling edge. Every bit is valid at the next rising edge. miso_oe_o is 1 while read data is driven.
- R4: The pointer is loaded from the low 10 bits of the 24-bit address, and the upper 14 bits are ignored. A low-10-bit value of 528 or more starts at that value minus 528.
- R5: After byte 527, the pointer wraps to byte 0 and the transfer continues, for both writes and reads.
- R6: A command ends when chip select goes high. Bits of an unfinished data byte are discarded and nothing is written for them. miso_oe_o is 0 whenever chip select is high.
- R7: If the lock bit of the target buffer (lock_i[0] for A, lock_i[1] for B) is 1 when the command code completes, the command is ignored. No byte is written and miso_oe_o stays 0. The unlocked buffer can still be written and read.
- R8: Any other command code is ignored until chip select goes high. It writes nothing and never drives data-out.
- R9: Serial clock mode 0 (idle low) and mode 3 (idle high) both work with the same results.
- R10: After reset, miso_oe_o is 0 and the block waits for a command code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Data-out enable (0 = high impedance) |
| lock_i | input | 2 | Per-buffer busy lock from the program engine (bit 0 = A, bit 1 = B) |
| eng_a_addr_i | input | 10 | Engine read address, buffer A |
| eng_a_data_o | output | 8 | Engine read data, buffer A |
| eng_b_addr_i | input | 10 | Engine read address, buffer B |
| eng_b_data_o | output | 8 | Engine read data, buffer B |

## Verification
A pointer that folds or wraps at the wrong place puts a byte into the wrong slot. That shows on the engine read port as soon as the command ends, and again on data-out when the same region is streamed back. A wrong bit count or a byte-phase slip appears within one byte as a shifted data-out value, or as an unfinished byte that was stored. A lock or decode state that lets a command through shows at once as a changed engine read value or as miso_oe_o rising. The directed tests cross the 527-to-0 boundary in both directions and use out-of-range and high-order addresses, in both clock modes.

// File: rtl/dfbuf_pkg.sv
// Package: shared sizes, command codes and the frame phase type of the
// dual byte-buffer unit. Assumes exactly two buffers (one code pair each).
package dfbuf_pkg;
    localparam int NUM_BUFS   = 2;
    localparam int BUF_BYTES  = 528;
    localparam int ADDR_W     = 10;
    localparam int ADDR_BYTES = 3;
    localparam int BYTE_W     = 8;
    localparam int BIT_CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] CMD_WR_A = 8'h84;
    localparam logic [BYTE_W-1:0] CMD_WR_B = 8'h87;
    localparam logic [BYTE_W-1:0] CMD_RD_A = 8'hD4;
    localparam logic [BYTE_W-1:0] CMD_RD_B = 8'hD6;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;
endpackage

// File: rtl/dfbuf_sync.sv
// Module: two-stage synchronizer for the slow serial inputs.
// Assumes the inputs change slowly compared with clk_i; each bit is
// synchronized on its own (bits stay aligned because they settle early).
module dfbuf_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Purpose: two flops in a row per bit, reset to the idle level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta <= RST_VAL;
            q_o  <= RST_VAL;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/dfbuf_store.sv
// Module: one byte buffer with a host write port, a host read port (used for
// streaming out) and an engine read port. Reads are combinational; addresses
// at or beyond BYTES read as zero. Contents are not cleared by reset.
module dfbuf_store #(
    parameter int BYTES = 528,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          lock_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    input  logic [AW-1:0] eaddr_i,
    output logic [DW-1:0] edata_o
);
    logic [DW-1:0] mem [BYTES];

    // Purpose: store one host byte when the frame asks for it.
    always_ff @(posedge clk_i) begin
        if (we_i && (32'(waddr_i) < BYTES)) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Purpose: guarded combinational reads for the host and engine ports.
    always_comb begin
        rdata_o = (32'(raddr_i) < BYTES) ? mem[raddr_i] : '0;
        edata_o = (32'(eaddr_i) < BYTES) ? mem[eaddr_i] : '0;
    end

    // R7: a locked buffer never takes a host byte
    a_r7_no_write_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |-> !lock_i);
    // R4: writes always land inside the buffer
    a_r4_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |-> (32'(waddr_i) < BYTES));
endmodule

// File: rtl/dfbuf_frame.sv
// Module: serial command framer. It counts bits on synchronized serial clock
// edges, decodes the command code, gathers the address, folds it into
// buffer range, and then streams bytes into or out of the selected buffer.
// Assumes edge strobes last one cycle and never coincide; a released chip
// select clears all frame state.
module dfbuf_frame
    import dfbuf_pkg::*;
#(
    parameter int NBUF   = NUM_BUFS,
    parameter int BYTES  = BUF_BYTES,
    parameter int AW     = ADDR_W,
    parameter int ABYTES = ADDR_BYTES
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        cs_act_i,
    input  logic                        sck_rise_i,
    input  logic                        sck_fall_i,
    input  logic                        mosi_i,
    input  logic [NBUF-1:0]             lock_i,
    input  logic [BYTE_W-1:0]           rd_byte_i,
    output logic [AW-1:0]               ptr_o,
    output logic [$clog2(NBUF)-1:0]     sel_o,
    output logic [NBUF-1:0]             wr_en_o,
    output logic [BYTE_W-1:0]           wr_byte_o,
    output logic                        miso_o,
    output logic                        miso_oe_o
);
    localparam int SW = $clog2(NBUF);
    localparam int CW = $clog2(ABYTES + 1);

    phase_t               phase;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]    shreg;
    logic [AW-2:0]        addr_sh;
    logic [CW-1:0]        abyte_cnt;
    logic                 is_rd;
    logic [SW-1:0]        sel;
    logic [AW-1:0]        ptr;
    logic [BIT_CNT_W-1:0] out_cnt;
    logic [BYTE_W-2:0]    tx;
    logic                 so, oe;

    logic                 byte_done, wr_step, rd_step;
    logic [BYTE_W-1:0]    new_byte;
    logic [AW-1:0]        new_addr;
    logic                 dec_ok, dec_rd;
    logic [SW-1:0]        dec_sel;

    // Purpose: fold an address into 0..BYTES-1 (input below 2*BYTES).
    function automatic logic [AW-1:0] fold(input logic [AW-1:0] a);
        return (32'(a) >= BYTES) ? AW'(32'(a) - BYTES) : a;
    endfunction

    // Purpose: next pointer with wrap from the last byte to byte 0.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (32'(p) == BYTES - 1) ? '0 : p + 1'b1;
    endfunction

    // Purpose: byte completion strobes and the assembled values.
    always_comb begin
        byte_done = sck_rise_i && (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
        new_byte  = {shreg, mosi_i};
        new_addr  = {addr_sh, mosi_i};
        wr_step   = byte_done && (phase == PH_DATA) && !is_rd;
        rd_step   = sck_fall_i && (phase == PH_DATA) && is_rd &&
                    (out_cnt == BIT_CNT_W'(BYTE_W - 1));
    end

    // Purpose: map a command code to direction and target buffer.
    always_comb begin
        dec_ok  = 1'b1;
        dec_rd  = 1'b0;
        dec_sel = '0;
        unique case (new_byte)
            CMD_WR_A: dec_sel = SW'(0);
            CMD_WR_B: dec_sel = SW'(1);
            CMD_RD_A: begin dec_rd = 1'b1; dec_sel = SW'(0); end
            CMD_RD_B: begin dec_rd = 1'b1; dec_sel = SW'(1); end
            default:  dec_ok = 1'b0;
        endcase
    end

    // Purpose: per-buffer write strobes, held off while a buffer is locked.
    always_comb begin
        for (int b = 0; b < NBUF; b++) begin
            wr_en_o[b] = wr_step && (sel == SW'(b)) && !lock_i[b];
        end
    end

    // Purpose: receive path, phase sequencing and pointer updates.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !cs_act_i) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            shreg     <= '0;
            addr_sh   <= '0;
            abyte_cnt <= '0;
            is_rd     <= 1'b0;
            sel       <= '0;
            ptr       <= '0;
        end else begin
            if (sck_rise_i) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= new_byte[BYTE_W-2:0];
                if (phase == PH_ADDR) begin
                    addr_sh <= new_addr[AW-2:0];
                end
            end
            if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        if (dec_ok && !lock_i[dec_sel]) begin
                            phase <= PH_ADDR;
                            is_rd <= dec_rd;
                            sel   <= dec_sel;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        abyte_cnt <= abyte_cnt + 1'b1;
                        if (abyte_cnt == CW'(ABYTES - 1)) begin
                            ptr   <= fold(new_addr);
                            phase <= PH_DATA;
                        end
                    end
                    default: ;
                endcase
            end
            if (wr_step || rd_step) begin
                ptr <= step(ptr);
            end
        end
    end

    // Purpose: transmit path, one bit per falling serial clock edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !cs_act_i) begin
            out_cnt <= '0;
            tx      <= '0;
            so      <= 1'b0;
            oe      <= 1'b0;
        end else if (sck_fall_i && (phase == PH_DATA) && is_rd) begin
            oe      <= 1'b1;
            out_cnt <= out_cnt + 1'b1;
            if (out_cnt == '0) begin
                so <= rd_byte_i[BYTE_W-1];
                tx <= rd_byte_i[BYTE_W-2:0];
            end else begin
                so <= tx[BYTE_W-2];
                tx <= {tx[BYTE_W-3:0], 1'b0};
            end
        end
    end

    assign ptr_o     = ptr;
    assign sel_o     = sel;
    assign wr_byte_o = new_byte;
    assign miso_o    = so;
    assign miso_oe_o = oe;

    // R4: the pointer never leaves the buffer
    a_r4_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(ptr) < BYTES);
    // R5: a step from the last byte lands on byte 0
    a_r5_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_act_i && (wr_step || rd_step) && (32'(ptr) == BYTES - 1)) |=> (ptr == '0));
    // R6: data-out released one cycle after chip select is seen high
    a_r6_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_act_i |=> !miso_oe_o);
    // R6: no byte is stored outside an active frame
    a_r6_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_act_i |-> (wr_en_o == '0));
    // R3: data-out only drives during a read command
    a_r3_drive_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miso_oe_o |-> is_rd);
endmodule

// File: rtl/dfbuf_unit.sv
// Module: top of the dual byte-buffer unit. It synchronizes the serial
// lines, finds serial clock edges, runs the framer, and instantiates one
// store per buffer. Assumes at least four system clocks per serial half period.
module dfbuf_unit
    import dfbuf_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sck_i,
    input  logic                cs_ni,
    input  logic                mosi_i,
    output logic                miso_o,
    output logic                miso_oe_o,
    input  logic [NUM_BUFS-1:0] lock_i,
    input  logic [ADDR_W-1:0]   eng_a_addr_i,
    output logic [BYTE_W-1:0]   eng_a_data_o,
    input  logic [ADDR_W-1:0]   eng_b_addr_i,
    output logic [BYTE_W-1:0]   eng_b_data_o
);
    localparam int SW = $clog2(NUM_BUFS);

    logic [2:0] line_sync;
    logic       sck_q;
    logic       cs_act, sck_rise, sck_fall, mosi_s;

    logic [ADDR_W-1:0]                eng_addr [NUM_BUFS];
    logic [BYTE_W-1:0]                eng_data [NUM_BUFS];
    logic [BYTE_W-1:0]                host_rd  [NUM_BUFS];
    logic [ADDR_W-1:0]                ptr;
    logic [SW-1:0]                    sel;
    logic [NUM_BUFS-1:0]              wr_en;
    logic [BYTE_W-1:0]                wr_byte;

    dfbuf_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({cs_ni, sck_i, mosi_i}),
        .q_o    (line_sync)
    );

    // Purpose: previous synchronized serial clock level for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sck_q <= 1'b0;
        else         sck_q <= line_sync[1];
    end

    assign cs_act   = !line_sync[2];
    assign sck_rise = line_sync[1] && !sck_q;
    assign sck_fall = !line_sync[1] && sck_q;
    assign mosi_s   = line_sync[0];

    assign eng_addr[0]  = eng_a_addr_i;
    assign eng_addr[1]  = eng_b_addr_i;
    assign eng_a_data_o = eng_data[0];
    assign eng_b_data_o = eng_data[1];

    dfbuf_frame u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cs_act_i   (cs_act),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .mosi_i     (mosi_s),
        .lock_i     (lock_i),
        .rd_byte_i  (host_rd[sel]),
        .ptr_o      (ptr),
        .sel_o      (sel),
        .wr_en_o    (wr_en),
        .wr_byte_o  (wr_byte),
        .miso_o     (miso_o),
        .miso_oe_o  (miso_oe_o)
    );

    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
        dfbuf_store #(.BYTES(BUF_BYTES), .AW(ADDR_W), .DW(BYTE_W)) u_store (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .we_i    (wr_en[b]),
            .waddr_i (ptr),
            .wdata_i (wr_byte),
            .lock_i  (lock_i[b]),
            .raddr_i (ptr),
            .rdata_o (host_rd[b]),
            .eaddr_i (eng_addr[b]),
            .edata_o (eng_data[b])
        );
    end

    // R10: nothing is driven during reset
    a_r10_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> !miso_oe_o);
    // R2: at most one buffer takes a byte per cycle
    a_r2_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(wr_en));
endmodule

// File: tb/dfbuf_unit_bench.sv
// Directed bench for the dual byte-buffer unit: one task per scenario.
module dfbuf_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [1:0] lock = 2'b00;
    logic [9:0] ea_addr = '0, eb_addr = '0;
    logic [7:0] ea_data, eb_data;
    logic       mode3 = 1'b0;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    dfbuf_unit u_dfbuf_unit (
        .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .lock_i(lock),
        .eng_a_addr_i(ea_addr), .eng_a_data_o(ea_data),
        .eng_b_addr_i(eb_addr), .eng_b_data_o(eb_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic r, output logic oe);
        @(negedge clk);
        mosi = b;
        if (mode3) sck = 1'b0;
        repeat (4) @(negedge clk);
        r  = miso;
        oe = miso_oe;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, inout logic oe_any);
        for (int i = 7; i >= 0; i--) begin
            logic r, oe;
            spi_bit(tx[i], r, oe);
            rx[i] = r;
            oe_any |= oe;
        end
    endtask

    task automatic frame_start(input logic [7:0] op, input logic [23:0] a, inout logic oe_any);
        logic [7:0] rx;
        @(negedge clk);
        sck = mode3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        spi_byte(op, rx, oe_any);
        spi_byte(a[23:16], rx, oe_any);
        spi_byte(a[15:8], rx, oe_any);
        spi_byte(a[7:0], rx, oe_any);
    endtask

    task automatic frame_end();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                          input int n, output logic oe_any);
        logic [7:0] rx;
        oe_any = 1'b0;
        frame_start(op, a, oe_any);
        for (int i = n - 1; i >= 0; i--) spi_byte(d[8*i +: 8], rx, oe_any);
        frame_end();
    endtask

    task automatic rd_cmd(input logic [7:0] op, input logic [23:0] a, input int n,
                          output logic [31:0] got, output logic oe_any);
        logic [7:0] rx;
        oe_any = 1'b0;
        got = '0;
        frame_start(op, a, oe_any);
        oe_any = 1'b0;
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, rx, oe_any);
            got = {got[23:0], rx};
        end
        frame_end();
    endtask

    task automatic eng(input int b, input int a, output logic [7:0] v);
        @(negedge clk);
        if (b == 0) ea_addr = 10'(a); else eb_addr = 10'(a);
        @(negedge clk);
        v = (b == 0) ? ea_data : eb_data;
    endtask

    task automatic t_reset();
        chk({31'd0, miso_oe}, 0, "R10 oe after reset");
    endtask

    task automatic t_write_read();
        logic oe; logic [31:0] g; logic [7:0] v;
        wr_cmd(8'h84, 24'h000005, 32'h00112233, 3, oe);
        chk({31'd0, oe}, 0, "R2 no drive on write");
        eng(0, 5, v); chk(v, 8'h11, "R2 A5");
        eng(0, 6, v); chk(v, 8'h22, "R1 A6");
        eng(0, 7, v); chk(v, 8'h33, "R2 A7");
        rd_cmd(8'hD4, 24'h000005, 3, g, oe);
        chk(g, 32'h00112233, "R3 stream A5..7");
        chk({31'd0, oe}, 1, "R3 oe while reading");
        chk({31'd0, miso_oe}, 0, "R6 oe after cs high");
    endtask

    task automatic t_buf_b();
        logic oe; logic [7:0] v; logic [31:0] g;
        wr_cmd(8'h87, 24'h000005, 32'h0000AABB, 2, oe);
        eng(1, 5, v); chk(v, 8'hAA, "R2 B5");
        eng(1, 6, v); chk(v, 8'hBB, "R1 B6");
        eng(0, 5, v); chk(v, 8'h11, "R1 A5 untouched by B write");
        rd_cmd(8'hD6, 24'h000005, 2, g, oe);
        chk(g, 32'h0000AABB, "R3 stream B5..6");
        eng(0, 600, v); chk(v, 8'h00, "R1 engine out of range");
    endtask

    task automatic t_addr();
        logic oe; logic [7:0] v;
        wr_cmd(8'h84, 24'hFFFC07, 32'h0000009D, 1, oe);
        eng(0, 7, v); chk(v, 8'h9D, "R4 upper bits ignored");
        wr_cmd(8'h84, 24'h000258, 32'h0000006E, 1, oe);
        eng(0, 72, v); chk(v, 8'h6E, "R4 600 folds to 72");
    endtask

    task automatic t_wrap();
        logic oe; logic [7:0] v; logic [31:0] g;
        wr_cmd(8'h87, 24'h00020E, 32'h01020304, 4, oe);
        eng(1, 526, v); chk(v, 8'h01, "R5 B526");
        eng(1, 527, v); chk(v, 8'h02, "R5 B527");
        eng(1, 0, v);   chk(v, 8'h03, "R5 write wrap B0");
        eng(1, 1, v);   chk(v, 8'h04, "R5 write wrap B1");
        rd_cmd(8'hD6, 24'h00020F, 2, g, oe);
        chk(g, 32'h00000203, "R5 read wrap 527->0");
    endtask

    task automatic t_lock();
        logic oe; logic [7:0] v; logic [31:0] g;
        lock = 2'b01;
        wr_cmd(8'h84, 24'h000005, 32'h000000EE, 1, oe);
        eng(0, 5, v); chk(v, 8'h11, "R7 locked A not written");
        rd_cmd(8'hD4, 24'h000005, 1, g, oe);
        chk({31'd0, oe}, 0, "R7 locked A read stays hi-Z");
        wr_cmd(8'h87, 24'h00000A, 32'h0000003C, 1, oe);
        eng(1, 10, v); chk(v, 8'h3C, "R7 B usable while A locked");
        rd_cmd(8'hD6, 24'h00000A, 1, g, oe);
        chk(g, 32'h0000003C, "R7 B readable while A locked");
        lock = 2'b00;
    endtask

    task automatic t_partial();
        logic oe; logic [7:0] v, rx;
        wr_cmd(8'h84, 24'h000014, 32'h00000044 | 32'h0, 2, oe);
        oe = 1'b0;
        frame_start(8'h84, 24'h000014, oe);
        spi_byte(8'h71, rx, oe);
        for (int i = 7; i >= 3; i--) begin
            logic r, o;
            spi_bit(v[0] ^ 1'b1, r, o);
        end
        frame_end();
        eng(0, 20, v); chk(v, 8'h71, "R6 full byte stored");
        eng(0, 21, v); chk(v, 8'h44, "R6 partial byte discarded");
        chk({31'd0, miso_oe}, 0, "R6 oe idle");
    endtask

    task automatic t_badop();
        logic oe; logic [7:0] v;
        wr_cmd(8'h55, 24'h000005, 32'h0000EEEE, 2, oe);
        chk({31'd0, oe}, 0, "R8 unknown code never drives");
        eng(0, 5, v); chk(v, 8'h11, "R8 A5 unchanged");
        eng(0, 6, v); chk(v, 8'h22, "R8 A6 unchanged");
    endtask

    task automatic t_mode3();
        logic oe; logic [7:0] v; logic [31:0] g;
        mode3 = 1'b1;
        wr_cmd(8'h84, 24'h000064, 32'h0000C35A, 2, oe);
        rd_cmd(8'hD4, 24'h000064, 2, g, oe);
        chk(g, 32'h0000C35A, "R9 mode 3 round trip");
        mode3 = 1'b0;
        eng(0, 101, v); chk(v, 8'h5A, "R9 mode 3 A101");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read();
        t_buf_b();
        t_addr();
        t_wrap();
        t_lock();
        t_partial();
        t_badop();
        t_mode3();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule